// File: doc/BRIEF.md
# Oversampled SPI Slave Byte Responder

This block acts as an SPI slave, mode 0, inside a fast system clock domain. Chip select, SCK and MOSI arrive as raw pins. Each pin is synchronized and then treated as ordinary data, so the system clock must run at six or more times the SPI bit rate.

A falling chip select starts a frame. The block then counts SPI clocks. During a programmable window of SPI clock positions it drives a preloaded byte on MISO, most significant bit first. The window defaults to clocks 17 through 24. Outside the window, MISO is released.

While the response is going out, every MOSI bit the master sends is shifted into a capture register. A complete frame is presented on a parallel output together with a one-cycle strobe. Every output change follows a sampled pin edge by the same number of system clocks in every frame, so the response latency never jitters.

Top module: `spi_resp_slave`

## Requirements
- R1: After reset, `miso`, `miso_oe` and `rx_valid` are 0 and `rx_data` is all zeros.
- R2: SPI clocks are numbered from 1 starting at the chip-select fall. For a clock k with window start ≤ k ≤ window end:
  - `miso_oe` is 1.
  - `miso` carries bit 7-(k-start) of the response byte, so the byte goes out MSB first.
  - The value is set after the SCK fall that ends clock k-1, or after the chip-select fall when k is 1, and it holds through the rise of clock k.
- R3: Outside the window, and whenever chip select is high, `miso_oe` is 0 and `miso` is 0.
- R4: An output change caused by a chip-select fall or an SCK fall appears exactly 3 system clocks after the pin edge, counting the 2 synchronizer stages and 1 output register. The delay is the same in every frame.
- R5: MOSI is sampled on each SCK rise. After the 24th rise of a frame:
  - `rx_data` holds the 24 received bits, with the first bit in bit 23.
  - `rx_valid` is 1 for exactly one cycle.
- R6: If chip select rises before 24 bits have been received, the partial capture is discarded. `rx_valid` stays 0, `rx_data` keeps its previous value and `miso_oe` drops.
- R7: Configuration writes use three addresses, each latched from `cfg_wdata` when `cfg_we` is 1:
  - Address 0 sets the response byte, reset value 0.
  - Address 1 sets the window start, reset value 17.
  - Address 2 sets the window end, reset value 24.
  - All three take effect only at the next chip-select fall. A write made during a frame leaves that frame unchanged.
- R8: SCK and MOSI activity while chip select is high has no effect: `miso_oe` stays 0 and nothing is captured.
- R9: Window clocks beyond the eighth window position keep `miso_oe` at 1 and drive `miso` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sample clock, at least 6x the SPI rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_pin | input | 1 | Raw active-low chip select |
| sck_pin | input | 1 | Raw SPI clock, sampled as data |
| mosi_pin | input | 1 | Raw master-out data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address (0 byte, 1 start, 2 end) |
| cfg_wdata | input | 8 | Configuration write data |
| miso | output | 1 | Slave-out data |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| rx_data | output | 24 | Last complete captured frame, first bit in MSB |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` is updated |

## Verification
Frames are driven at exactly six system clocks per SPI bit. Two response bytes, 0xA5 and 0x3C, are paired with alternating and irregular MOSI words. These pairs separate a correct MSB-first order and window position from a reversed or shifted byte, and they catch MOSI bits captured on the wrong edge.

A window that starts at clock 1 pins down the 3-cycle latency across repeated frames. A window wider than eight clocks shows the zero fill. A frame cut short and SCK toggling with chip select high show that nothing leaks out or is captured. A write in mid-frame separates the double-buffered behaviour from immediate update.

// File: rtl/spi_resp_pkg.sv
// Shared definitions for the oversampled SPI slave responder.
// Assumes the configuration address is 2 bits wide.
package spi_resp_pkg;

    localparam int CFG_ADDR_W = 2;

    // Configuration register selects; the host relies on these codes.
    typedef enum logic [CFG_ADDR_W-1:0] {
        CFG_RESP_BYTE = 2'd0,
        CFG_WIN_START = 2'd1,
        CFG_WIN_END   = 2'd2
    } cfg_sel_e;

endpackage

// File: rtl/spi_sync_bit.sv
// Multi-stage synchronizer for one asynchronous pin.
// Assumes STAGES >= 2 and that the pin is held longer than one clock period.
module spi_sync_bit #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], pin};
    end

    assign lvl = chain_q[STAGES-1];

endmodule

// File: rtl/spi_edge_det.sv
// Rising and falling edge detector on an already synchronized level.
// Each edge flag is high for the single cycle in which the level first differs
// from the previous sample. Assumes the input is synchronous to clk.
module spi_edge_det #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev_q;

    // Remember the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/spi_resp_regs.sv
// Host-side shadow registers: response byte, window start and window end.
// The frame controller copies these at each chip-select fall, which makes a
// write during a frame take effect at the next frame only.
module spi_resp_regs
    import spi_resp_pkg::*;
#(
    parameter int            DATA_W    = 8,
    parameter logic [7:0]    WIN_START = 8'd17,
    parameter logic [7:0]    WIN_END   = 8'd24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [DATA_W-1:0]     resp_sh,
    output logic [DATA_W-1:0]     wstart_sh,
    output logic [DATA_W-1:0]     wend_sh
);

    // Latch host writes into the addressed shadow register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_sh   <= '0;
            wstart_sh <= DATA_W'(WIN_START);
            wend_sh   <= DATA_W'(WIN_END);
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_addr))
                CFG_RESP_BYTE: resp_sh   <= cfg_wdata;
                CFG_WIN_START: wstart_sh <= cfg_wdata;
                CFG_WIN_END:   wend_sh   <= cfg_wdata;
                default:       ;
            endcase
        end
    end

endmodule

// File: rtl/spi_frame_ctrl.sv
// Frame controller. It counts SCK falls since the chip-select fall, drives the
// response window on MISO, and shifts MOSI on each SCK rise into a capture
// register. Assumes edge flags come from synchronized pins (SPI mode 0).
// Outputs are registered from next-state values, so each reacts in the same
// cycle the edge flag is seen.
module spi_frame_ctrl #(
    parameter int DATA_W     = 8,
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  mosi_s,
    input  logic [DATA_W-1:0]     resp_sh,
    input  logic [DATA_W-1:0]     wstart_sh,
    input  logic [DATA_W-1:0]     wend_sh,
    output logic                  miso,
    output logic                  miso_oe,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  rx_valid
);

    localparam int               CNT_W    = DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

    logic                  active_q, active_n;
    logic [CNT_W-1:0]      fcnt_q, fcnt_n;
    logic [CNT_W-1:0]      rcnt_q;
    logic [DATA_W-1:0]     byte_q, byte_n;
    logic [DATA_W-1:0]     ws_q, ws_n;
    logic [DATA_W-1:0]     we_q, we_n;
    logic [FRAME_BITS-1:0] cap_q;
    logic [FRAME_BITS-1:0] cap_shift;
    logic [CNT_W:0]        clk_idx;
    logic [CNT_W:0]        win_off;
    logic [DATA_W-1:0]     byte_shl;
    logic                  in_win;
    logic                  miso_n;

    // Next frame state: start on CS fall, stop on CS rise, count SCK falls.
    always_comb begin
        active_n = active_q;
        fcnt_n   = fcnt_q;
        byte_n   = byte_q;
        ws_n     = ws_q;
        we_n     = we_q;
        if (cs_fall) begin
            active_n = 1'b1;
            fcnt_n   = '0;
            byte_n   = resp_sh;
            ws_n     = wstart_sh;
            we_n     = wend_sh;
        end else if (cs_rise) begin
            active_n = 1'b0;
        end else if (active_q && sck_fall && fcnt_q != CNT_MAX) begin
            fcnt_n = fcnt_q + 1'b1;
        end
    end

    // Decide the MISO value for the SPI clock that comes next.
    always_comb begin
        clk_idx  = {1'b0, fcnt_n} + 1'b1;
        in_win   = active_n && (clk_idx >= {1'b0, ws_n}) && (clk_idx <= {1'b0, we_n});
        win_off  = clk_idx - {1'b0, ws_n};
        byte_shl = byte_n << win_off;
        miso_n   = in_win & byte_shl[DATA_W-1];
    end

    // Register frame state and the MISO outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            fcnt_q   <= '0;
            byte_q   <= '0;
            ws_q     <= '0;
            we_q     <= '0;
            miso     <= 1'b0;
            miso_oe  <= 1'b0;
        end else begin
            active_q <= active_n;
            fcnt_q   <= fcnt_n;
            byte_q   <= byte_n;
            ws_q     <= ws_n;
            we_q     <= we_n;
            miso     <= miso_n;
            miso_oe  <= in_win;
        end
    end

    assign cap_shift = {cap_q[FRAME_BITS-2:0], mosi_s};

    // Shift MOSI on SCK rises; publish the word when the frame is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt_q   <= '0;
            cap_q    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (cs_fall || cs_rise) begin
                rcnt_q <= '0;
                cap_q  <= '0;
            end else if (active_q && sck_rise && rcnt_q < FULL_CNT) begin
                cap_q  <= cap_shift;
                rcnt_q <= rcnt_q + 1'b1;
                if (rcnt_q == LAST_BIT) begin
                    rx_data  <= cap_shift;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_resp_slave.sv
// Top level of the oversampled SPI slave responder. Raw pins are synchronized
// in the system clock domain. Assumes clk runs at no less than 6x the SCK rate
// and that the master samples MISO on the SCK rise (mode 0).
module spi_resp_slave
    import spi_resp_pkg::*;
#(
    parameter int         DATA_W      = 8,
    parameter int         FRAME_BITS  = 24,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] WIN_START   = 8'd17,
    parameter logic [7:0] WIN_END     = 8'd24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_pin,
    input  logic                  sck_pin,
    input  logic                  mosi_pin,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic                  miso,
    output logic                  miso_oe,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  rx_valid
);

    logic              cs_s, sck_s, mosi_s;
    logic              cs_rise, cs_fall, sck_rise, sck_fall;
    logic [DATA_W-1:0] resp_sh, wstart_sh, wend_sh;

    spi_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .pin(cs_n_pin), .lvl(cs_s)
    );
    spi_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .pin(sck_pin), .lvl(sck_s)
    );
    spi_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .pin(mosi_pin), .lvl(mosi_s)
    );

    spi_edge_det #(.RST_VAL(1'b1)) u_edge_cs (
        .clk(clk), .rst_n(rst_n), .lvl(cs_s), .rise(cs_rise), .fall(cs_fall)
    );
    spi_edge_det #(.RST_VAL(1'b0)) u_edge_sck (
        .clk(clk), .rst_n(rst_n), .lvl(sck_s), .rise(sck_rise), .fall(sck_fall)
    );

    spi_resp_regs #(
        .DATA_W(DATA_W), .WIN_START(WIN_START), .WIN_END(WIN_END)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .resp_sh(resp_sh), .wstart_sh(wstart_sh),
        .wend_sh(wend_sh)
    );

    spi_frame_ctrl #(.DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .resp_sh(resp_sh), .wstart_sh(wstart_sh), .wend_sh(wend_sh),
        .miso(miso), .miso_oe(miso_oe), .rx_data(rx_data), .rx_valid(rx_valid)
    );

endmodule

// File: rtl/spi_resp_slave_chk.sv
// Property checker for spi_resp_slave, attached with bind below.
// Observes the synchronized chip-select level, the edge flags and the outputs.
module spi_resp_slave_chk #(
    parameter int FRAME_BITS = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_s,
    input logic                  cs_fall,
    input logic                  cs_rise,
    input logic                  sck_fall,
    input logic                  miso,
    input logic                  miso_oe,
    input logic                  rx_valid,
    input logic [FRAME_BITS-1:0] rx_data
);

    AST_IDLE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !cs_rise) |-> !miso_oe); // R3
    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso); // R3
    AST_OE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> $past(cs_fall || sck_fall)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data)); // R6
    AST_ABORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !miso_oe); // R6

endmodule

bind spi_resp_slave spi_resp_slave_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_fall(sck_fall), .miso(miso), .miso_oe(miso_oe),
    .rx_valid(rx_valid), .rx_data(rx_data)
);

// File: tb/spi_resp_slave_bench.sv
`timescale 1ns/1ps
// Directed bench: acts as the SPI master at 6 system clocks per bit.
module spi_resp_slave_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n_pin = 1'b1;
    logic        sck_pin = 1'b0;
    logic        mosi_pin = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        miso, miso_oe, rx_valid;
    logic [23:0] rx_data;

    int          total = 0;
    int          bad = 0;
    int          rx_count = 0;
    logic [23:0] rx_last = '0;

    always #2.5 clk = ~clk;

    spi_resp_slave u_spi_resp_slave (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
        .mosi_pin(mosi_pin), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .miso(miso), .miso_oe(miso_oe),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    // Count capture strobes and remember the word, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_count = rx_count + 1;
            rx_last  = rx_data;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // One frame of nbits; checks MISO/OE before every SCK rise; optional mid-frame write.
    task automatic run_frame(input logic [31:0] mosi_word, input int nbits,
                             input logic [7:0] exp_byte, input int ws, input int we,
                             input string req, input int wr_at, input logic [7:0] wr_byte);
        @(negedge clk); cs_n_pin = 1'b0;
        for (int k = 1; k <= nbits; k++) begin
            int   off;
            logic e_oe, e_miso;
            mosi_pin = mosi_word[nbits-k];
            repeat (3) @(negedge clk);
            off    = k - ws;
            e_oe   = (k >= ws) && (k <= we);
            e_miso = e_oe && (off < 8) ? exp_byte[7-off] : 1'b0;
            check(req, $sformatf("oe clk %0d", k), int'(miso_oe), int'(e_oe));
            check(req, $sformatf("miso clk %0d", k), int'(miso), int'(e_miso));
            sck_pin = 1'b1;
            if (k == wr_at) begin
                @(negedge clk); cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = wr_byte;
                @(negedge clk); cfg_we = 1'b0;
                @(negedge clk);
            end else begin
                repeat (3) @(negedge clk);
            end
            sck_pin = 1'b0;
        end
        repeat (3) @(negedge clk);
        cs_n_pin = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "miso", int'(miso), 0);
        check("R1", "miso_oe", int'(miso_oe), 0);
        check("R1", "rx_valid", int'(rx_valid), 0);
        check("R1", "rx_data", int'(rx_data), 0);
    endtask

    // Default window 17..24 from reset values (R7), byte MSB first (R2, R3), capture (R5).
    task automatic t_default_frames;
        int c0;
        cfg_write(2'd0, 8'hA5);
        c0 = rx_count;
        run_frame(32'h00AA_55C3, 24, 8'hA5, 17, 24, "R2", 0, 8'h00);
        check("R5", "rx strobes", rx_count - c0, 1);
        check("R5", "rx word", int'(rx_last), 32'h00AA55C3);
        check("R3", "oe after frame", int'(miso_oe), 0);
        cfg_write(2'd0, 8'h3C);
        run_frame(32'h0013_9E61, 24, 8'h3C, 17, 24, "R2", 0, 8'h00);
        check("R5", "rx strobes 2", rx_count - c0, 2);
        check("R5", "rx word 2", int'(rx_last), 32'h00139E61);
    endtask

    // Chip select rises after 20 bits while the response window is open: no capture (R6).
    task automatic t_abort;
        int          c0;
        logic [23:0] keep;
        c0 = rx_count; keep = rx_data;
        run_frame(32'h000F_0F0F, 20, 8'h3C, 17, 24, "R6", 0, 8'h00);
        check("R6", "no strobe", rx_count - c0, 0);
        check("R6", "rx_data kept", int'(rx_data), int'(keep));
        check("R6", "oe dropped", int'(miso_oe), 0);
    endtask

    // SCK and MOSI toggling with chip select high (R8).
    task automatic t_idle_sck;
        int c0;
        int oe_seen;
        c0 = rx_count; oe_seen = 0;
        for (int i = 0; i < 30; i++) begin
            mosi_pin = i[0];
            sck_pin  = ~sck_pin;
            repeat (3) @(negedge clk);
            if (miso_oe) oe_seen++;
        end
        sck_pin = 1'b0;
        repeat (4) @(negedge clk);
        check("R8", "oe while deselected", oe_seen, 0);
        check("R8", "no capture", rx_count - c0, 0);
    endtask

    // Write during a frame only affects the next frame (R7).
    task automatic t_double_buffer;
        cfg_write(2'd0, 8'hC3);
        run_frame(32'h0000_0000, 24, 8'hC3, 17, 24, "R7", 5, 8'h5A);
        run_frame(32'h00FF_FFFF, 24, 8'h5A, 17, 24, "R7", 0, 8'h00);
        check("R7", "all-ones capture", int'(rx_last), 32'h00FFFFFF);
    endtask

    // Window starting at clock 1: output appears exactly 3 clocks after CS falls (R4).
    task automatic t_latency;
        cfg_write(2'd1, 8'd1);
        cfg_write(2'd2, 8'd8);
        cfg_write(2'd0, 8'h80);
        for (int f = 0; f < 3; f++) begin
            @(negedge clk); cs_n_pin = 1'b0;
            repeat (2) @(negedge clk);
            check("R4", $sformatf("oe at 2 cycles f%0d", f), int'(miso_oe), 0);
            @(negedge clk);
            check("R4", $sformatf("oe at 3 cycles f%0d", f), int'(miso_oe), 1);
            check("R4", $sformatf("miso at 3 cycles f%0d", f), int'(miso), 1);
            cs_n_pin = 1'b1;
            repeat (6) @(negedge clk);
        end
        run_frame(32'h0012_3456, 24, 8'h80, 1, 8, "R4", 0, 8'h00);
    endtask

    // Window of 10 clocks: positions past the byte drive 0 with OE high (R9).
    task automatic t_long_window;
        cfg_write(2'd1, 8'd3);
        cfg_write(2'd2, 8'd12);
        cfg_write(2'd0, 8'hFF);
        run_frame(32'h00AB_CDEF, 24, 8'hFF, 3, 12, "R9", 0, 8'h00);
        check("R5", "rx word long", int'(rx_last), 32'h00ABCDEF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_default_frames();
        t_abort();
        t_idle_sck();
        t_double_buffer();
        t_latency();
        t_long_window();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule